// File: doc/BRIEF.md
# Serial DAC Frame and Command Decoder

This block sits on the transmit side of a power-line analog front end. A baseband device sends it 16-bit serial frames over three pins: a transmit clock, a transmit data line and a conversion-start strobe. The block cuts each frame into a 10-bit DAC sample and a 4-bit command field. It passes the sample to the DAC with a one-cycle valid flag. The command field can change the predriver gain code from one frame to the next. It can also drive indirect writes into the configuration register space through an address register, a high data byte and an address that steps forward after each write.

All three serial pins are sampled in the block's own system clock domain. Edges of the transmit clock are found by a synchronizer and an edge detector. Four configuration inputs set how the block behaves:
- which transmit-clock edge samples the strobe;
- whether the first data bit is delayed by one cycle;
- whether in-frame gain updates are allowed;
- whether read-flagged indirect accesses are honoured as reads, which here means they are suppressed.

The frame deserializer is a state machine with four states:
- `FR_IDLE` waits for the strobe to be seen high and then low at the selected sampling edge.
- `FR_SKIP` lets one transmit-clock falling edge pass when rising-edge strobe sampling and the one-cycle data delay are both selected.
- `FR_SHIFT` captures one bit on each falling edge of the transmit clock.
- `FR_DONE` presents the captured frame for exactly one cycle.

Its transitions are:
- `FR_IDLE`→`FR_SHIFT` on a start. The bit is taken at once when falling-edge sampling is used with no delay.
- `FR_IDLE`→`FR_SKIP` on a start when rising-edge sampling is used with the delay.
- `FR_SKIP`→`FR_SHIFT` on the next falling edge.
- `FR_SHIFT`→`FR_DONE` on the sixteenth captured bit.
- `FR_DONE`→`FR_IDLE` unconditionally.

Top module: `afe_tx_frame_decoder`

## Requirements
- R1: After reset:
  - `gain_code` is 4'b0101.
  - `dac_valid` and `wr_strobe` are low.
  - The indirect address register is 0, so the first indirect write with no address load goes to address 0.
- R2: A frame starts when the strobe is sampled high and then low on consecutive sampling edges of the transmit clock. With `cfg_conv_rise`=0 the strobe is sampled on falling edges, and with 1 on rising edges. Data bits are always captured on falling edges of the transmit clock, 16 bits per frame.
- R3: When `cfg_data_delay`=0, the first frame bit is the one captured on the first falling edge at or after the start edge. When it is 1, that falling edge is skipped and the first bit is the one on the following falling edge.
- R4: Frame bits arrive in this order:
  - two don't-care bits;
  - D9..D0, MSB first;
  - C3..C0.

  A frame with C3=0 puts D9..D0 on `dac_sample` and raises `dac_valid` for exactly one cycle.
- R5: When `cfg_dyn_gain`=1 and C3=0, C2..C0 set `gain_code`:

  | C2..C0 | `gain_code` |
  |--------|-------------|
  | 000 | unchanged |
  | 001 | 0001 |
  | 010 | 0010 |
  | 011 | 0011 |
  | 100 | 0101 |
  | 101 | 0110 |
  | 110 | 0111 |
  | 111 | 1000 |
- R6: When `cfg_dyn_gain`=0, `gain_code` keeps its value. Samples are still delivered.
- R7: Command 1000 loads the indirect address from D7..D1 and the read/write flag from D0 (1 = read).
- R8: Command 1010, when it is a write access, loads D7..D0 into the high byte of the indirect data word.
- R9: Command 1001, when it is a write access, issues one `wr_strobe` pulse. The pulse carries the current indirect address and the data {high byte, D7..D0}. The address is then incremented, wrapping from 0x7F to 0x00.
- R10: Commands 1011 and 11xx change no output and no held state: no sample, no gain change, no write, no change to the address or the high byte.
- R11: An access counts as a read only when `cfg_read_mode`=1 and the loaded flag is 1. Commands 1010 and 1001 then have no effect. With `cfg_read_mode`=0 the flag is ignored and all accesses are writes.
- R12: Frames with C3=1 never raise `dac_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_clk | input | 1 | Transmit serial clock from the baseband |
| tx_data | input | 1 | Transmit serial data |
| tx_conv | input | 1 | Conversion-start strobe, active low |
| cfg_conv_rise | input | 1 | 0: sample strobe on falling edge, 1: on rising edge |
| cfg_data_delay | input | 1 | 1: first data bit one transmit cycle after start |
| cfg_dyn_gain | input | 1 | Enables in-frame gain updates |
| cfg_read_mode | input | 1 | Honours the read flag of indirect accesses |
| dac_sample | output | 10 | Last delivered DAC sample |
| dac_valid | output | 1 | One-cycle pulse with each new sample |
| gain_code | output | 4 | Predriver gain code |
| wr_addr | output | 7 | Indirect write address |
| wr_data | output | 16 | Indirect write data |
| wr_strobe | output | 1 | One-cycle register write pulse |

## Verification
The hardest situation to reach from the ports is the combination of rising-edge strobe sampling with the one-cycle data delay. There the block must pass one falling edge without capturing it, and a wrong count moves every field by one bit. The bench sends the same bit stream under all four edge and delay settings, with sample values whose misalignment would show up in both the sample and the command field. The address wrap and the suppression of reads are reached by loading the address just below 0x7F and by loading a read flag with read mode on and then off.

// File: rtl/afe_txfr_pkg.sv
package afe_txfr_pkg;

    // Fixed frame layout: pad bits, sample bits, command bits.
    localparam int PAD_W  = 2;
    localparam int CMD_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SKIP,
        FR_SHIFT,
        FR_DONE
    } frame_state_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_DAC,
        K_ADDR,
        K_HI,
        K_LO
    } cmd_kind_e;

    function automatic cmd_kind_e classify(input logic [CMD_W-1:0] c);
        cmd_kind_e k;
        unique casez (c)
            4'b0???: k = K_DAC;
            4'b1000: k = K_ADDR;
            4'b1010: k = K_HI;
            4'b1001: k = K_LO;
            default: k = K_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/tx_pin_sync.sv
module tx_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_clk,
    input  logic tx_data,
    input  logic tx_conv,
    output logic rise_p,
    output logic fall_p,
    output logic data_s,
    output logic conv_s
);
    // Bit 2: tx_clk, bit 1: tx_conv, bit 0: tx_data
    localparam logic [2:0] IDLE_PINS = 3'b010;

    logic [2:0] pipe [STAGES];
    logic       clk_prev;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= IDLE_PINS;
                    else        pipe[g] <= {tx_clk, tx_conv, tx_data};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= IDLE_PINS;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_prev <= 1'b0;
        else        clk_prev <= pipe[STAGES-1][2];
    end

    assign rise_p = pipe[STAGES-1][2] & ~clk_prev;
    assign fall_p = ~pipe[STAGES-1][2] & clk_prev;
    assign conv_s = pipe[STAGES-1][1];
    assign data_s = pipe[STAGES-1][0];
endmodule

// File: rtl/frame_deserializer.sv
module frame_deserializer
    import afe_txfr_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int BODY_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_p,
    input  logic              fall_p,
    input  logic              data_s,
    input  logic              conv_s,
    input  logic              cfg_conv_rise,
    input  logic              cfg_data_delay,
    output logic              frame_valid,
    output logic [BODY_W-1:0] frame_body
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    frame_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [BODY_W-1:0] shreg_q;
    logic             conv_prev_q;
    logic             samp_p;
    logic             start;
    logic             capture;

    assign samp_p = cfg_conv_rise ? rise_p : fall_p;
    assign start  = samp_p & conv_prev_q & ~conv_s;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // Next state and capture decision
    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            FR_IDLE: begin
                if (start) begin
                    if (!cfg_conv_rise && !cfg_data_delay) begin
                        capture = fall_p;
                        state_d = FR_SHIFT;
                    end else if (cfg_conv_rise && cfg_data_delay) begin
                        state_d = FR_SKIP;
                    end else begin
                        state_d = FR_SHIFT;
                    end
                end
            end
            FR_SKIP: begin
                if (fall_p) state_d = FR_SHIFT;
            end
            FR_SHIFT: begin
                if (fall_p) begin
                    capture = 1'b1;
                    if (cnt_q == CNT_W'(FRAME_W - 1)) state_d = FR_DONE;
                end
            end
            FR_DONE: begin
                state_d = FR_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        frame_valid = (state_q == FR_DONE);
        frame_body  = shreg_q;
    end

    // Datapath: strobe history, bit counter, shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_prev_q <= 1'b0;
            cnt_q       <= '0;
            shreg_q     <= '0;
        end else begin
            if (samp_p) conv_prev_q <= conv_s;
            if (capture) begin
                shreg_q <= {shreg_q[BODY_W-2:0], data_s};
                cnt_q   <= cnt_q + 1'b1;
            end else if (state_q == FR_IDLE || state_q == FR_DONE) begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import afe_txfr_pkg::*;
#(
    parameter int SAMPLE_W = 10,
    parameter int ADDR_W   = 7,
    parameter int REG_W    = 16,
    parameter int GAIN_W   = 4,
    parameter logic [GAIN_W-1:0] GAIN_RESET = 4'd5,
    localparam int BODY_W  = SAMPLE_W + CMD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [BODY_W-1:0]   frame_body,
    input  logic                cfg_dyn_gain,
    input  logic                cfg_read_mode,
    output logic [SAMPLE_W-1:0] dac_sample,
    output logic                dac_valid,
    output logic [GAIN_W-1:0]   gain_code,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [REG_W-1:0]    wr_data,
    output logic                wr_strobe
);
    logic [CMD_W-1:0]    cmd;
    logic [SAMPLE_W-1:0] payload;
    cmd_kind_e           kind;
    logic [ADDR_W-1:0]   addr_q;
    logic                rw_q;
    logic [BYTE_W-1:0]   hi_q;
    logic                write_ok;
    logic [GAIN_W-1:0]   gain_map;

    assign cmd      = frame_body[CMD_W-1:0];
    assign payload  = frame_body[BODY_W-1:CMD_W];
    assign kind     = classify(cmd);
    assign write_ok = !(cfg_read_mode && rw_q);

    // Codes 1..3 map directly, 4..7 skip the code 4.
    always_comb begin
        if (cmd[2:0] < 3'd4) gain_map = GAIN_W'(cmd[2:0]);
        else                 gain_map = GAIN_W'(cmd[2:0]) + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dac_sample <= '0;
            dac_valid  <= 1'b0;
            gain_code  <= GAIN_RESET;
            wr_addr    <= '0;
            wr_data    <= '0;
            wr_strobe  <= 1'b0;
            addr_q     <= '0;
            rw_q       <= 1'b0;
            hi_q       <= '0;
        end else begin
            dac_valid <= 1'b0;
            wr_strobe <= 1'b0;
            if (frame_valid) begin
                unique case (kind)
                    K_DAC: begin
                        dac_sample <= payload;
                        dac_valid  <= 1'b1;
                        if (cfg_dyn_gain && cmd[2:0] != 3'd0) gain_code <= gain_map;
                    end
                    K_ADDR: begin
                        addr_q <= payload[ADDR_W:1];
                        rw_q   <= payload[0];
                    end
                    K_HI: begin
                        if (write_ok) hi_q <= payload[BYTE_W-1:0];
                    end
                    K_LO: begin
                        if (write_ok) begin
                            wr_addr   <= addr_q;
                            wr_data   <= {hi_q, payload[BYTE_W-1:0]};
                            wr_strobe <= 1'b1;
                            addr_q    <= addr_q + 1'b1;
                        end
                    end
                    K_NONE: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/afe_tx_frame_decoder.sv
module afe_tx_frame_decoder
    import afe_txfr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int SAMPLE_W    = 10,
    parameter int ADDR_W      = 7,
    parameter int REG_W       = 16,
    parameter int GAIN_W      = 4,
    parameter logic [GAIN_W-1:0] GAIN_RESET = 4'd5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_clk,
    input  logic                tx_data,
    input  logic                tx_conv,
    input  logic                cfg_conv_rise,
    input  logic                cfg_data_delay,
    input  logic                cfg_dyn_gain,
    input  logic                cfg_read_mode,
    output logic [SAMPLE_W-1:0] dac_sample,
    output logic                dac_valid,
    output logic [GAIN_W-1:0]   gain_code,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [REG_W-1:0]    wr_data,
    output logic                wr_strobe
);
    localparam int BODY_W  = SAMPLE_W + CMD_W;
    localparam int FRAME_W = PAD_W + BODY_W;

    logic              rise_p;
    logic              fall_p;
    logic              data_s;
    logic              conv_s;
    logic              frame_valid;
    logic [BODY_W-1:0] frame_body;

    tx_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_clk  (tx_clk),
        .tx_data (tx_data),
        .tx_conv (tx_conv),
        .rise_p  (rise_p),
        .fall_p  (fall_p),
        .data_s  (data_s),
        .conv_s  (conv_s)
    );

    frame_deserializer #(.FRAME_W(FRAME_W), .BODY_W(BODY_W)) u_deser (
        .clk            (clk),
        .rst_n          (rst_n),
        .rise_p         (rise_p),
        .fall_p         (fall_p),
        .data_s         (data_s),
        .conv_s         (conv_s),
        .cfg_conv_rise  (cfg_conv_rise),
        .cfg_data_delay (cfg_data_delay),
        .frame_valid    (frame_valid),
        .frame_body     (frame_body)
    );

    cmd_decoder #(
        .SAMPLE_W   (SAMPLE_W),
        .ADDR_W     (ADDR_W),
        .REG_W      (REG_W),
        .GAIN_W     (GAIN_W),
        .GAIN_RESET (GAIN_RESET)
    ) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_valid   (frame_valid),
        .frame_body    (frame_body),
        .cfg_dyn_gain  (cfg_dyn_gain),
        .cfg_read_mode (cfg_read_mode),
        .dac_sample    (dac_sample),
        .dac_valid     (dac_valid),
        .gain_code     (gain_code),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .wr_strobe     (wr_strobe)
    );
endmodule

// File: rtl/afe_txfr_checks.sv
module afe_txfr_checks #(
    parameter int GAIN_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_valid,
    input logic              dac_valid,
    input logic              wr_strobe,
    input logic              cfg_dyn_gain,
    input logic [GAIN_W-1:0] gain_code
);
    assert_dac_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |=> !dac_valid);

    assert_dac_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> $past(frame_valid));

    assert_gain_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_code != 0) && (gain_code != 4) && (gain_code <= 8));

    assert_gain_with_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_code) |-> dac_valid);

    assert_gain_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_code) |-> $past(cfg_dyn_gain));

    assert_write_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> $past(frame_valid));

    assert_write_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    assert_no_dual_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_strobe && dac_valid));
endmodule

bind afe_tx_frame_decoder afe_txfr_checks #(.GAIN_W(GAIN_W)) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid  (frame_valid),
    .dac_valid    (dac_valid),
    .wr_strobe    (wr_strobe),
    .cfg_dyn_gain (cfg_dyn_gain),
    .gain_code    (gain_code)
);

// File: tb/afe_tx_frame_decoder_bench.sv
`timescale 1ns/1ps
module afe_tx_frame_decoder_bench;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_clk = 1'b0;
    logic        tx_data = 1'b0;
    logic        tx_conv = 1'b1;
    logic        cfg_conv_rise = 1'b0;
    logic        cfg_data_delay = 1'b0;
    logic        cfg_dyn_gain = 1'b1;
    logic        cfg_read_mode = 1'b0;
    logic [9:0]  dac_sample;
    logic        dac_valid;
    logic [3:0]  gain_code;
    logic [6:0]  wr_addr;
    logic [15:0] wr_data;
    logic        wr_strobe;

    int n_chk = 0;
    int n_fail = 0;
    int n_dac = 0;
    int n_wr = 0;
    int last_sample = 0;
    int last_waddr = 0;
    int last_wdata = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    afe_tx_frame_decoder u_afe_tx_frame_decoder (
        .clk(clk), .rst_n(rst_n), .tx_clk(tx_clk), .tx_data(tx_data), .tx_conv(tx_conv),
        .cfg_conv_rise(cfg_conv_rise), .cfg_data_delay(cfg_data_delay),
        .cfg_dyn_gain(cfg_dyn_gain), .cfg_read_mode(cfg_read_mode),
        .dac_sample(dac_sample), .dac_valid(dac_valid), .gain_code(gain_code),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_strobe(wr_strobe)
    );

    always @(negedge clk) begin
        if (dac_valid) begin
            n_dac++;
            last_sample = int'(dac_sample);
        end
        if (wr_strobe) begin
            n_wr++;
            last_waddr = int'(wr_addr);
            last_wdata = int'(wr_data);
        end
    end

    task automatic chk(input string tag, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic tx_cycle(input logic d, input logic c);
        @(negedge clk);
        tx_data = d;
        tx_conv = c;
        repeat (H) @(negedge clk);
        tx_clk = 1'b1;
        repeat (H) @(negedge clk);
        tx_clk = 1'b0;
    endtask

    task automatic send_frame(input logic [15:0] f);
        tx_cycle(1'b0, 1'b1);
        tx_cycle(1'b0, 1'b1);
        for (int i = 0; i < 17; i++) begin
            int idx;
            logic d;
            idx = cfg_data_delay ? i - 1 : i;
            d = (idx >= 0 && idx < 16) ? f[15 - idx] : 1'b0;
            tx_cycle(d, (i == 0) ? 1'b0 : 1'b1);
        end
        tx_cycle(1'b0, 1'b1);
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [15:0] mkf(input logic [9:0] s, input logic [3:0] c);
        return {2'b10, s, c};
    endfunction

    function automatic logic [15:0] mka(input logic [6:0] a, input logic rw);
        return {2'b01, 2'b00, a, rw, 4'b1000};
    endfunction

    function automatic int gmap(input int c, input int prev);
        if (c == 0) return prev;
        if (c < 4) return c;
        return c + 1;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int dac0, wr0, g;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk("R1 gain reset", int'(gain_code), 5);
        chk("R1 dac_valid reset", int'(dac_valid), 0);
        chk("R1 wr_strobe reset", int'(wr_strobe), 0);
        send_frame(mkf(10'h012, 4'b1010));
        send_frame(mkf(10'h034, 4'b1001));
        chk("R1 address reset", last_waddr, 0);
        chk("R8 R9 first write data", last_wdata, 16'h1234);

        // R2 R3 R4: samples under all four edge/delay settings
        for (int m = 0; m < 4; m++) begin
            cfg_conv_rise = m[0];
            cfg_data_delay = m[1];
            for (int k = 0; k < 12; k++) begin
                int s;
                s = (k == 0) ? 0 : (k == 1) ? 1023 : (k * 293 + m * 71 + 5) % 1024;
                dac0 = n_dac;
                send_frame(mkf(10'(s), 4'b0000));
                chk($sformatf("R2 R3 R4 pulse m%0d", m), n_dac - dac0, 1);
                chk($sformatf("R2 R3 R4 sample m%0d", m), last_sample, s);
            end
            chk("R5 code 000 keeps gain", int'(gain_code), 5);
        end

        // R5 gain map sweep
        cfg_conv_rise = 1'b0;
        cfg_data_delay = 1'b0;
        g = 5;
        for (int c = 1; c < 9; c++) begin
            int cc;
            cc = c % 8;
            dac0 = n_dac;
            send_frame(mkf(10'(c * 37), 4'(cc)));
            g = gmap(cc, g);
            chk("R5 gain map", int'(gain_code), g);
            chk("R4 sample with gain", last_sample, c * 37);
            chk("R4 pulse with gain", n_dac - dac0, 1);
        end

        // R6 dynamic gain disabled
        send_frame(mkf(10'd3, 4'b0001));
        chk("R5 gain 001", int'(gain_code), 1);
        cfg_dyn_gain = 1'b0;
        for (int c = 1; c < 8; c++) begin
            send_frame(mkf(10'(100 + c), 4'(c)));
            chk("R6 gain frozen", int'(gain_code), 1);
            chk("R6 sample still delivered", last_sample, 100 + c);
        end
        cfg_dyn_gain = 1'b1;

        // R7 R9 address load, post increment and wrap
        dac0 = n_dac;
        send_frame(mka(7'h7E, 1'b0));
        send_frame(mkf(10'h0A5, 4'b1010));
        wr0 = n_wr;
        send_frame(mkf(10'h001, 4'b1001));
        chk("R7 loaded address", last_waddr, 8'h7E);
        chk("R9 write data", last_wdata, 16'hA501);
        send_frame(mkf(10'h002, 4'b1001));
        chk("R9 increment", last_waddr, 8'h7F);
        chk("R9 high byte kept", last_wdata, 16'hA502);
        send_frame(mkf(10'h003, 4'b1001));
        chk("R9 wrap", last_waddr, 0);
        chk("R9 one strobe per frame", n_wr - wr0, 3);
        chk("R12 no sample on commands", n_dac - dac0, 0);

        // R10 reserved commands
        dac0 = n_dac;
        wr0 = n_wr;
        send_frame(mkf(10'h0FF, 4'b1011));
        for (int c = 12; c < 16; c++) send_frame(mkf(10'h03C, 4'(c)));
        chk("R10 no write", n_wr - wr0, 0);
        chk("R10 R12 no sample", n_dac - dac0, 0);
        chk("R10 gain kept", int'(gain_code), 1);
        send_frame(mkf(10'h004, 4'b1001));
        chk("R10 address kept", last_waddr, 1);
        chk("R10 high byte kept", last_wdata, 16'hA504);

        // R11 read mode
        cfg_read_mode = 1'b1;
        send_frame(mka(7'h10, 1'b1));
        wr0 = n_wr;
        send_frame(mkf(10'h077, 4'b1010));
        send_frame(mkf(10'h088, 4'b1001));
        chk("R11 read suppresses write", n_wr - wr0, 0);
        cfg_read_mode = 1'b0;
        send_frame(mkf(10'h066, 4'b1010));
        send_frame(mkf(10'h055, 4'b1001));
        chk("R11 flag ignored addr", last_waddr, 8'h10);
        chk("R11 flag ignored data", last_wdata, 16'h6655);
        cfg_read_mode = 1'b1;
        send_frame(mka(7'h20, 1'b0));
        send_frame(mkf(10'h011, 4'b1010));
        send_frame(mkf(10'h022, 4'b1001));
        chk("R7 R11 write flag addr", last_waddr, 8'h20);
        chk("R7 R11 write flag data", last_wdata, 16'h1122);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule